// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes an operation code, the accumulator value, a second operand and the current carry, and it produces an 8-bit result combinationally. Five condition bits are kept in a register beside the datapath: sign, zero, auxiliary (nibble) carry, parity and carry. Each operation class updates its own subset of these bits.

The supported operations are addition, subtraction, increment, decrement, AND, OR, XOR, complement, and four accumulator rotates. The rotates go left or right, either as a plain circular shift or through the carry bit. The flag register loads only on a rising clock edge, and only when the flag write enable is high. The surrounding control logic feeds the stored carry back on `cy_i` when it wants true through-carry behaviour. It can also present any other carry value.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, and after its synchronised release, `flags_o` reads 0. Bit order of `flags_o` is {sign, zero, aux, parity, carry} on bits 4..0.
- R2: Opcode 0 (add) gives `acc_i + opnd_i` modulo 256. Carry is set on a carry out of bit 7. Aux is set on a carry out of bit 3.
- R3: Opcode 1 (subtract) gives `acc_i - opnd_i` modulo 256. Carry is set when `acc_i < opnd_i` (borrow). Aux is set when the low nibble of `acc_i` is below the low nibble of `opnd_i`.
- R4: Opcode 2 (increment) and opcode 3 (decrement) add or subtract 1 from `acc_i` and ignore `opnd_i`. Aux is set when the low nibble of `acc_i` is 0xF on increment, or 0x0 on decrement. Carry keeps its stored value.
- R5: For opcodes 0 to 6, sign takes result bit 7. Zero is set exactly when the result is 0. Parity is set exactly when the result has an even number of ones.
- R6: Opcodes 4, 5 and 6 give bitwise AND, OR and XOR of `acc_i` and `opnd_i`, and clear both carry and aux.
- R7: Opcode 7 gives the bitwise inverse of `acc_i` and changes no flag.
- R8: Opcode 8 (plain rotate left) moves each bit up one place, with bit 7 going into bit 0 and into carry. No flag other than carry changes.
- R9: Opcode 9 (rotate left through carry) moves bit 7 into carry and `cy_i` into bit 0. Only carry changes.
- R10: Opcode 10 (plain rotate right) moves bit 0 into bit 7 and into carry. Opcode 11 (rotate right through carry) moves bit 0 into carry and `cy_i` into bit 7. Only carry changes.
- R11: `flags_o` changes only on a rising clock edge with `flag_we_i` high. With `flag_we_i` low the flags hold.
- R12: Opcodes 12 to 15 pass `acc_i` to the result and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| cy_i | input | 1 | Carry presented to the rotates through carry |
| flag_we_i | input | 1 | Flag register load enable |
| result_o | output | 8 | Combinational result |
| flags_o | output | 5 | Registered flags {S, Z, AC, P, CY} |

## Verification
The hardest situations are the ones where a flag must stay put while neighbouring flags change. One case is increment or decrement after the stored carry has been set by an earlier operation. Another is a rotate that follows an operation which left sign, zero and parity in a non-trivial state. The stimulus reaches these by chaining operations. For example, an overflowing add is followed by an increment, and a result with sign and odd parity is followed by rotates. Directed nibble-boundary operands (0x0F, 0xF0, 0x10, 0xFF, 0x00) cover the aux carry and borrow edges. A long randomised run with random write enables exercises the hold behaviour.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_N = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CPL = 4'd7,
    OP_RLP = 4'd8,
    OP_RLC = 4'd9,
    OP_RRP = 4'd10,
    OP_RRC = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_t;

  localparam logic [FLAG_N-1:0] UPD_ALL   = 5'b11111;
  localparam logic [FLAG_N-1:0] UPD_NO_CY = 5'b11110;
  localparam logic [FLAG_N-1:0] UPD_CY    = 5'b00001;
  localparam logic [FLAG_N-1:0] UPD_NONE  = 5'b00000;

endpackage

// File: rtl/acc_arith.sv
module acc_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] rhs;
  logic              do_sub;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    low;

  // operand select: the constant one replaces the second operand for inc/dec
  always_comb begin
    rhs    = '0;
    do_sub = 1'b0;
    unique case (op_i)
      OP_ADD: begin rhs = b_i; do_sub = 1'b0; end
      OP_SUB: begin rhs = b_i; do_sub = 1'b1; end
      OP_INC: begin rhs = ONE; do_sub = 1'b0; end
      OP_DEC: begin rhs = ONE; do_sub = 1'b1; end
      default: begin rhs = '0; do_sub = 1'b0; end
    endcase
  end

  // one extra bit catches carry on add and borrow (wrap) on subtract
  always_comb begin
    if (do_sub) begin
      wide = {1'b0, a_i} - {1'b0, rhs};
      low  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]};
    end else begin
      wide = {1'b0, a_i} + {1'b0, rhs};
      low  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]};
    end
  end

  assign res_o = wide[DATA_W-1:0];
  assign cy_o  = wide[DATA_W];
  assign ac_o  = low[NIB_W];

  always_comb begin
    if (op_i == OP_SUB) begin
      AST_SUB_BORROW: assert (cy_o == (a_i < b_i)) else $error("borrow mismatch"); // R3
    end
  end

endmodule

// File: rtl/acc_bitops.sv
module acc_bitops
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] rot_l;
  logic [DATA_W-1:0] rot_r;
  logic              fill_l;
  logic              fill_r;

  // plain rotates recycle the outgoing bit, through-carry ones take cy_i
  assign fill_l = (op_i == OP_RLC) ? cy_i : a_i[MSB];
  assign fill_r = (op_i == OP_RRC) ? cy_i : a_i[0];

  assign rot_l[0]   = fill_l;
  assign rot_r[MSB] = fill_r;

  for (genvar gi = 1; gi < DATA_W; gi++) begin : g_shift
    assign rot_l[gi]   = a_i[gi-1];
    assign rot_r[gi-1] = a_i[gi];
  end

  always_comb begin
    res_o = a_i;
    cy_o  = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_RLP, OP_RLC: begin res_o = rot_l; cy_o = a_i[MSB]; end
      OP_RRP, OP_RRC: begin res_o = rot_r; cy_o = a_i[0];   end
      default: res_o = a_i;
    endcase
  end

  always_comb begin
    if (op_i == OP_RLP || op_i == OP_RRP) begin
      AST_ROT_KEEPS_ONES: assert ($countones(res_o) == $countones(a_i)) else $error("plain rotate lost a bit"); // R8
    end
  end

endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [FLAG_N-1:0] cand_i,
  input  logic [FLAG_N-1:0] upd_i,
  output logic [FLAG_N-1:0] flags_o,
  output logic              rst_sync_n_o
);

  logic [1:0]        sync_q;
  logic              rst_sync_n;
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] flags_d;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

  // per-bit merge of the candidate with the held value
  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_merge
    assign flags_d[gi] = upd_i[gi] ? cand_i[gi] : flags_q[gi];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
    end else if (we_i) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o      = flags_q;
  assign rst_sync_n_o = rst_sync_n;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !we_i |=> $stable(flags_q)) else $error("flags moved without enable"); // R11

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cy_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_N-1:0] flags_o
);

  alu_op_e           op_e;
  logic [DATA_W-1:0] ar_res;
  logic              ar_cy;
  logic              ar_ac;
  logic [DATA_W-1:0] bo_res;
  logic              bo_cy;
  flag_t             cand;
  logic [FLAG_N-1:0] upd;
  logic [DATA_W-1:0] res;
  logic              sync_rst_n;

  assign op_e = alu_op_e'(op_i);

  acc_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) arith_i (
    .op_i  (op_e),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .res_o (ar_res),
    .cy_o  (ar_cy),
    .ac_o  (ar_ac)
  );

  acc_bitops #(.DATA_W(DATA_W)) bitops_i (
    .op_i  (op_e),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cy_i  (cy_i),
    .res_o (bo_res),
    .cy_o  (bo_cy)
  );

  // result select and per-class flag update mask
  always_comb begin
    res  = acc_i;
    cand = '0;
    upd  = UPD_NONE;
    unique case (op_e)
      OP_ADD, OP_SUB: begin
        res = ar_res; cand.cy = ar_cy; cand.ac = ar_ac; upd = UPD_ALL;
      end
      OP_INC, OP_DEC: begin
        res = ar_res; cand.ac = ar_ac; upd = UPD_NO_CY;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = bo_res; upd = UPD_ALL;
      end
      OP_CPL: begin
        res = bo_res; upd = UPD_NONE;
      end
      OP_RLP, OP_RLC, OP_RRP, OP_RRC: begin
        res = bo_res; cand.cy = bo_cy; upd = UPD_CY;
      end
      default: begin
        res = acc_i; upd = UPD_NONE;
      end
    endcase
    cand.s = res[DATA_W-1];
    cand.z = ~|res;
    cand.p = ~^res;
  end

  assign result_o = res;

  acc_flag_reg flag_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (flag_we_i),
    .cand_i       (cand),
    .upd_i        (upd),
    .flags_o      (flags_o),
    .rst_sync_n_o (sync_rst_n)
  );

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && $past(flag_we_i) && ($past(op_i) <= 4'd6))
    |-> (flags_o[3] == ($past(result_o) == '0))) else $error("zero flag wrong"); // R5

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && $past(flag_we_i) && ($past(op_i) >= 4'd4) && ($past(op_i) <= 4'd6))
    |-> (flags_o[2] == 1'b0 && flags_o[0] == 1'b0)) else $error("logic op left carry"); // R6

  AST_INCDEC_CY: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && (($past(op_i) == 4'd2) || ($past(op_i) == 4'd3)))
    |-> (flags_o[0] == $past(flags_o[0]))) else $error("inc/dec touched carry"); // R4

  AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && ($past(op_i) >= 4'd8) && ($past(op_i) <= 4'd11))
    |-> (flags_o[4:1] == $past(flags_o[4:1]))) else $error("rotate touched other flags"); // R8

endmodule

// File: tb/acc_alu_core_tb.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;

  localparam real CLK_HALF = 2.5;

  logic       clk;
  logic       rst_n;
  logic [3:0] op_i;
  logic [7:0] acc_i;
  logic [7:0] opnd_i;
  logic       cy_i;
  logic       flag_we_i;
  logic [7:0] result_o;
  logic [4:0] flags_o;

  int checks;
  int errors;

  logic [4:0] ref_fl;
  logic [4:0] exp_q[$];
  string      req_q[$];

  acc_alu_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .acc_i     (acc_i),
    .opnd_i    (opnd_i),
    .cy_i      (cy_i),
    .flag_we_i (flag_we_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {result, next flags} from the requirement text; flags {S,Z,AC,P,CY}
  function automatic logic [12:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic c, input logic [4:0] fl);
    logic [7:0] r;
    logic       s, z, ac, p, cy;
    logic [8:0] t;
    {s, z, ac, p, cy} = fl;
    r = a;
    case (op)
      4'd0: begin t = a + b; r = t[7:0]; cy = t[8]; ac = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15; end
      4'd1: begin r = a - b; cy = (a < b); ac = (a[3:0] < b[3:0]); end
      4'd2: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); end
      4'd3: begin r = a - 8'd1; ac = (a[3:0] == 4'h0); end
      4'd4: begin r = a & b; ac = 1'b0; cy = 1'b0; end
      4'd5: begin r = a | b; ac = 1'b0; cy = 1'b0; end
      4'd6: begin r = a ^ b; ac = 1'b0; cy = 1'b0; end
      4'd7: r = ~a;
      4'd8: begin r = {a[6:0], a[7]}; cy = a[7]; end
      4'd9: begin r = {a[6:0], c};    cy = a[7]; end
      4'd10: begin r = {a[0], a[7:1]}; cy = a[0]; end
      4'd11: begin r = {c, a[7:1]};    cy = a[0]; end
      default: r = a;
    endcase
    if (op <= 4'd6) begin
      s = r[7];
      z = (r == 8'h00);
      p = ($countones(r) % 2) == 0;
    end
    return {r, s, z, ac, p, cy};
  endfunction

  // driver: apply at falling edge, check result, queue the flags due after the next rising edge
  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic we, input string req);
    logic [12:0] m;
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; cy_i = c; flag_we_i = we;
    m = model(op, a, b, c, ref_fl);
    #1;
    chk(result_o === m[12:5], req, result_o, m[12:5]);
    chk(flags_o === ref_fl, "R11 no change before edge", {3'b0, flags_o}, {3'b0, ref_fl});
    if (we) ref_fl = m[4:0];
    exp_q.push_back(ref_fl);
    req_q.push_back(req);
  endtask

  // monitor: compare registered flags after each rising edge
  always begin
    logic [4:0] e;
    string      r;
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(flags_o === e, {r, " flags"}, {3'b0, flags_o}, {3'b0, e});
    end
  end

  initial begin
    #(CLK_HALF * 2 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; ref_fl = 5'b0;
    rst_n = 1'b0; op_i = 4'd0; acc_i = 8'h00; opnd_i = 8'h00; cy_i = 1'b0; flag_we_i = 1'b0;
    #12;
    chk(flags_o === 5'b0, "R1 in reset", {3'b0, flags_o}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(flags_o === 5'b0, "R1 after release", {3'b0, flags_o}, 8'h00);

    // R2 add: nibble carry, full carry with zero, plain
    drive(4'd0, 8'h0F, 8'h01, 1'b0, 1'b1, "R2 add nibble carry");
    drive(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, "R2 add overflow to zero");
    drive(4'd0, 8'h12, 8'h34, 1'b0, 1'b1, "R2 add plain");
    drive(4'd0, 8'h80, 8'h80, 1'b0, 1'b1, "R2 add carry no aux");
    // R4 carry held by inc after a set carry
    drive(4'd2, 8'hFF, 8'h55, 1'b0, 1'b1, "R4 inc wraps, carry kept");
    drive(4'd2, 8'h3F, 8'h00, 1'b0, 1'b1, "R4 inc aux");
    // R3 subtract borrows
    drive(4'd1, 8'h00, 8'h01, 1'b0, 1'b1, "R3 sub borrow");
    drive(4'd1, 8'h50, 8'h50, 1'b0, 1'b1, "R3 sub to zero");
    drive(4'd1, 8'h20, 8'h0F, 1'b0, 1'b1, "R3 sub nibble borrow");
    drive(4'd3, 8'h10, 8'h00, 1'b0, 1'b1, "R4 dec nibble borrow");
    drive(4'd3, 8'h01, 8'hFF, 1'b0, 1'b1, "R4 dec to zero");
    // R5/R6 logical
    drive(4'd0, 8'hF0, 8'h20, 1'b0, 1'b1, "R2 set carry before logic");
    drive(4'd4, 8'hF3, 8'h8E, 1'b0, 1'b1, "R6 and clears carry");
    drive(4'd5, 8'h00, 8'h00, 1'b0, 1'b1, "R5 or zero");
    drive(4'd6, 8'hA5, 8'h01, 1'b0, 1'b1, "R5 xor odd parity");
    // R7 complement keeps flags
    drive(4'd7, 8'h5A, 8'h00, 1'b1, 1'b1, "R7 complement");
    // rotates after a sign/odd-parity state
    drive(4'd6, 8'h80, 8'h00, 1'b0, 1'b1, "R5 sign set");
    drive(4'd8, 8'h81, 8'h00, 1'b0, 1'b1, "R8 rotate left plain");
    drive(4'd8, 8'h40, 8'h00, 1'b1, 1'b1, "R8 rotate left plain no carry");
    drive(4'd9, 8'h80, 8'h00, 1'b0, 1'b1, "R9 rotate left through carry 0");
    drive(4'd9, 8'h01, 8'h00, 1'b1, 1'b1, "R9 rotate left through carry 1");
    drive(4'd10, 8'h01, 8'h00, 1'b0, 1'b1, "R10 rotate right plain");
    drive(4'd11, 8'h02, 8'h00, 1'b1, 1'b1, "R10 rotate right through carry");
    drive(4'd11, 8'h03, 8'h00, 1'b0, 1'b1, "R10 rotate right through carry 0");
    // R11 hold with enable low
    drive(4'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, "R11 add with enable low");
    drive(4'd4, 8'h00, 8'h00, 1'b0, 1'b0, "R11 and with enable low");
    // R12 undefined codes
    for (int k = 12; k < 16; k++) drive(4'(k), 8'h00, 8'hFF, 1'b1, 1'b1, "R12 unused opcode");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      drive(op, 8'($urandom), 8'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
            (op <= 4'd1) ? "R2 R3 random arith" :
            (op <= 4'd3) ? "R4 random inc/dec" :
            (op <= 4'd7) ? "R6 R7 random logic" :
            (op <= 4'd11) ? "R10 random rotate" : "R12 random unused");
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule